// File: doc/BRIEF.md
# Idle Chip-Select Release Timer for Memory-Mapped Flash Reads

This block owns the flash chip-select line while an external serial flash is read through a memory-mapped window. A read access pulls chip select low. The interface then keeps prefetching the bytes that follow, and chip select stays low. When the prefetch buffer reports full, an idle counter is armed with a programmed period. If no new access arrives before that period runs out, chip select is driven high so the flash can drop to its lower-power state. A sticky timeout flag is set at the same moment. Software clears the flag by writing one, and a separate enable passes it to an interrupt line.

Once chip select has been released, the next access is held back until chip select has been high for the programmed minimum number of cycles. The timeout enable, the idle period and the minimum-high field sit in local registers. These registers accept writes only while no command is active.

Top module: `cs_idle_timeout`

## Requirements
- R1: After reset, `csN` is 1, `busy` is 0, `timeoutFlag` is 0 and `timeoutIrq` is 0, and the minimum-high wait counts as already served.
- R2: An access sampled while `csN` is 1 and the minimum high time has been served drives `csN` to 0 at that same clock edge. `busy` always equals the inverse of `csN`.
- R3: Take the enable as set, `fnMode` as 2'b11 (memory-mapped) and `csN` as 0. Let edge E0 be the first edge that samples `bufFull` high, and let P be the idle period. If no access follows, `csN` stays 0 through edge E0+P and rises at edge E0+P+1. `timeoutFlag` is set at that same edge.
- R4: With a period of 0, `csN` rises at the first edge after E0.
- R5: With the timeout enable clear, `csN` stays 0 for as long as no release happens, whatever the state of `bufFull`.
- R6: With `fnMode` at any value other than 2'b11, no release takes place. Once the mode returns to 2'b11 while the buffer is full, the counter arms and release follows after the period.
- R7: An access sampled while `csN` is 0 cancels any pending release and disarms the counter. If `bufFull` is still high, a full new period starts on the next edge.
- R8: `timeoutFlag` holds its value until a cycle with `flagClr` high, after which it reads 0.
- R9: `timeoutIrq` is `timeoutFlag` AND `irqEn`.
- R10: After a release, `csN` stays high for at least `cfgCsHigh`+1 cycles. An access that arrives earlier is held and takes effect at the first edge where the minimum has been served.
- R11: `cfgWe` writes to the enable, the period and the minimum-high field have no effect while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fnMode | input | 2 | Functional mode; 2'b11 is memory-mapped |
| accessReq | input | 1 | One-cycle pulse for a new memory-mapped access |
| bufFull | input | 1 | Prefetch buffer full |
| cfgWe | input | 1 | Configuration write strobe |
| cfgTimeoutEn | input | 1 | Timeout enable value to write |
| cfgIdlePeriod | input | 16 | Idle period value to write, in clock cycles |
| cfgCsHigh | input | 3 | Minimum-high field to write (high time is value+1 cycles) |
| irqEn | input | 1 | Timeout interrupt enable |
| flagClr | input | 1 | Write-one-to-clear strobe for the timeout flag |
| csN | output | 1 | Flash chip select, active low |
| busy | output | 1 | A command is active (chip select low) |
| timeoutFlag | output | 1 | Sticky idle timeout flag |
| timeoutIrq | output | 1 | Gated timeout interrupt |

## Verification
The assertions assume three things about the inputs. `accessReq` is a single-cycle pulse per access. `bufFull` only describes the buffer while chip select is low. `fnMode` changes away from a clock edge. The stimulus drives every input on the falling edge and never holds `accessReq` for more than one cycle. It also issues configuration writes only at points where the expected outcome, accepted or ignored, is known. A final pass deliberately leaves chip select low with the enable clear, because in that state the block has no way to raise it again.

// File: rtl/cit_pkg.sv
package cit_pkg;
  localparam logic [1:0] MODE_MAPPED = 2'b11;

  typedef struct packed {
    logic loadIdle;   // arm: load idle counter with period
    logic decIdle;    // count one idle cycle
    logic startHigh;  // chip select released this edge
  } cit_strobe_t;
endpackage

// File: rtl/cit_datapath.sv
module cit_datapath
  import cit_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int CSHT_W   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busy,
  input  logic                csN,
  input  logic                cfgWe,
  input  logic                cfgTimeoutEn,
  input  logic [PERIOD_W-1:0] cfgIdlePeriod,
  input  logic [CSHT_W-1:0]   cfgCsHigh,
  input  cit_strobe_t         strb,
  output logic                tcEn,
  output logic                idleZero,
  output logic                highMet
);
  localparam int HIGH_W = CSHT_W + 1;
  localparam logic [HIGH_W-1:0] HIGH_MAX = HIGH_W'(1 << CSHT_W);

  logic [PERIOD_W-1:0] periodReg;
  logic [CSHT_W-1:0]   cshtReg;
  logic [PERIOD_W-1:0] idleCnt;
  logic [HIGH_W-1:0]   highCnt;

  // configuration shadow, writable only when idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tcEn      <= 1'b0;
      periodReg <= '0;
      cshtReg   <= '0;
    end else if (cfgWe && !busy) begin
      tcEn      <= cfgTimeoutEn;
      periodReg <= cfgIdlePeriod;
      cshtReg   <= cfgCsHigh;
    end
  end

  // idle down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (strb.loadIdle) begin
      idleCnt <= periodReg;
    end else if (strb.decIdle && idleCnt != '0) begin
      idleCnt <= idleCnt - 1'b1;
    end
  end

  // cycles spent with chip select high, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highCnt <= HIGH_MAX;
    end else if (strb.startHigh) begin
      highCnt <= HIGH_W'(1);
    end else if (csN && highCnt != HIGH_MAX) begin
      highCnt <= highCnt + 1'b1;
    end
  end

  assign idleZero = (idleCnt == '0);
  assign highMet  = (highCnt > {1'b0, cshtReg});

  a_r11_cfg_frozen_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(periodReg) && $stable(cshtReg) && $stable(tcEn)));

  a_r3_counter_never_wraps: assert property (@(posedge clk) disable iff (!rstN)
    (idleZero && !strb.loadIdle) |=> idleZero);
endmodule

// File: rtl/cit_control.sv
module cit_control
  import cit_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  fnMode,
  input  logic        accessReq,
  input  logic        bufFull,
  input  logic        tcEn,
  input  logic        idleZero,
  input  logic        highMet,
  input  logic        flagClr,
  input  logic        irqEn,
  output cit_strobe_t strb,
  output logic        csN,
  output logic        timeoutFlag,
  output logic        timeoutIrq
);
  logic armed;
  logic pending;
  logic active;
  logic relNow;
  logic fallNow;

  assign active = tcEn && (fnMode == MODE_MAPPED);

  always_comb begin
    strb = '0;
    if (!csN && active && !accessReq) begin
      if (armed) begin
        if (idleZero) strb.startHigh = 1'b1;
        else          strb.decIdle   = 1'b1;
      end else if (bufFull) begin
        strb.loadIdle = 1'b1;
      end
    end
  end

  assign relNow  = strb.startHigh;
  assign fallNow = csN && (pending || accessReq) && highMet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csN         <= 1'b1;
      armed       <= 1'b0;
      pending     <= 1'b0;
      timeoutFlag <= 1'b0;
    end else begin
      if (relNow)       csN <= 1'b1;
      else if (fallNow) csN <= 1'b0;

      if (relNow || accessReq || !active) armed <= 1'b0;
      else if (strb.loadIdle)             armed <= 1'b1;

      if (fallNow)                pending <= 1'b0;
      else if (csN && accessReq)  pending <= 1'b1;

      if (relNow)       timeoutFlag <= 1'b1;
      else if (flagClr) timeoutFlag <= 1'b0;
    end
  end

  assign timeoutIrq = timeoutFlag && irqEn;

  a_r3_expiry_releases: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && armed && active && idleZero && !accessReq) |=> (csN && timeoutFlag));

  a_r5_inactive_holds_low: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !active) |=> !csN);

  a_r7_access_cancels: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && accessReq) |=> (!csN && !armed));

  a_r10_min_high_served: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> $past(highMet));

  a_r8_clear_works: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !relNow) |=> !timeoutFlag);
endmodule

// File: rtl/cs_idle_timeout.sv
module cs_idle_timeout
  import cit_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int CSHT_W   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          fnMode,
  input  logic                accessReq,
  input  logic                bufFull,
  input  logic                cfgWe,
  input  logic                cfgTimeoutEn,
  input  logic [PERIOD_W-1:0] cfgIdlePeriod,
  input  logic [CSHT_W-1:0]   cfgCsHigh,
  input  logic                irqEn,
  input  logic                flagClr,
  output logic                csN,
  output logic                busy,
  output logic                timeoutFlag,
  output logic                timeoutIrq
);
  cit_strobe_t strb;
  logic tcEn;
  logic idleZero;
  logic highMet;

  assign busy = ~csN;

  cit_datapath #(.PERIOD_W(PERIOD_W), .CSHT_W(CSHT_W)) u_dp (
    .clk(clk), .rstN(rstN), .busy(busy), .csN(csN),
    .cfgWe(cfgWe), .cfgTimeoutEn(cfgTimeoutEn),
    .cfgIdlePeriod(cfgIdlePeriod), .cfgCsHigh(cfgCsHigh),
    .strb(strb), .tcEn(tcEn), .idleZero(idleZero), .highMet(highMet)
  );

  cit_control u_ctl (
    .clk(clk), .rstN(rstN), .fnMode(fnMode), .accessReq(accessReq),
    .bufFull(bufFull), .tcEn(tcEn), .idleZero(idleZero), .highMet(highMet),
    .flagClr(flagClr), .irqEn(irqEn), .strb(strb), .csN(csN),
    .timeoutFlag(timeoutFlag), .timeoutIrq(timeoutIrq)
  );
endmodule

// File: tb/cs_idle_timeout_bench.sv
module cs_idle_timeout_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  fnMode = 2'b11;
  logic        accessReq = 1'b0;
  logic        bufFull = 1'b0;
  logic        cfgWe = 1'b0;
  logic        cfgTimeoutEn = 1'b0;
  logic [15:0] cfgIdlePeriod = '0;
  logic [2:0]  cfgCsHigh = '0;
  logic        irqEn = 1'b0;
  logic        flagClr = 1'b0;
  logic        csN, busy, timeoutFlag, timeoutIrq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cs_idle_timeout u_cs_idle_timeout (
    .clk(clk), .rstN(rstN), .fnMode(fnMode), .accessReq(accessReq),
    .bufFull(bufFull), .cfgWe(cfgWe), .cfgTimeoutEn(cfgTimeoutEn),
    .cfgIdlePeriod(cfgIdlePeriod), .cfgCsHigh(cfgCsHigh), .irqEn(irqEn),
    .flagClr(flagClr), .csN(csN), .busy(busy), .timeoutFlag(timeoutFlag),
    .timeoutIrq(timeoutIrq)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic edgeSample();
    @(posedge clk); #1;
  endtask

  task automatic cfgWrite(input logic en, input logic [15:0] per, input logic [2:0] csht);
    @(negedge clk);
    cfgWe = 1'b1; cfgTimeoutEn = en; cfgIdlePeriod = per; cfgCsHigh = csht;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic pulseAccess();
    @(negedge clk); accessReq = 1'b1;
    @(negedge clk); accessReq = 1'b0;
  endtask

  task automatic clearFlag();
    @(negedge clk); flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0;
  endtask

  task automatic testReset();
    chk("R1", "csN", csN, 1'b1);
    chk("R1", "busy", busy, 1'b0);
    chk("R1", "flag", timeoutFlag, 1'b0);
    chk("R1", "irq", timeoutIrq, 1'b0);
  endtask

  // period 3, write of 20 while busy must be ignored
  task automatic testTimeout();
    cfgWrite(1'b1, 16'd3, 3'd2);
    pulseAccess();
    chk("R2", "csN after access", csN, 1'b0);
    chk("R2", "busy after access", busy, 1'b1);
    cfgWrite(1'b1, 16'd20, 3'd0);
    @(negedge clk); bufFull = 1'b1;
    for (int k = 0; k <= 3; k++) begin
      edgeSample();
      chk("R3", "csN before expiry", csN, 1'b0);
    end
    edgeSample();
    chk("R3", "csN at expiry", csN, 1'b1);
    chk("R3", "flag at expiry", timeoutFlag, 1'b1);
    chk("R11", "old period kept", csN, 1'b1);
    chk("R9", "irq masked", timeoutIrq, 1'b0);
  endtask

  // csht kept at 2 (write while busy ignored): 3 high cycles
  task automatic testMinHigh();
    @(negedge clk); bufFull = 1'b0; accessReq = 1'b1;
    @(negedge clk); accessReq = 1'b0;
    chk("R10", "high cycle 1", csN, 1'b1);
    edgeSample();
    chk("R10", "high cycle 2", csN, 1'b1);
    edgeSample();
    chk("R10", "falls after min high", csN, 1'b0);
  endtask

  task automatic testFlagIrq();
    @(negedge clk); irqEn = 1'b1;
    #1;
    chk("R9", "irq enabled", timeoutIrq, 1'b1);
    repeat (5) @(negedge clk);
    chk("R8", "flag sticky", timeoutFlag, 1'b1);
    clearFlag();
    chk("R8", "flag cleared", timeoutFlag, 1'b0);
    chk("R9", "irq follows flag", timeoutIrq, 1'b0);
  endtask

  // access at 4th edge cancels, then full period again
  task automatic testCancel();
    @(negedge clk); bufFull = 1'b1;
    for (int k = 0; k < 3; k++) begin
      edgeSample();
      chk("R7", "low before cancel", csN, 1'b0);
    end
    pulseAccess();
    chk("R7", "low at cancel", csN, 1'b0);
    for (int k = 0; k < 4; k++) begin
      edgeSample();
      chk("R7", "low during restart", csN, 1'b0);
    end
    edgeSample();
    chk("R7", "release after restart", csN, 1'b1);
    @(negedge clk); bufFull = 1'b0;
    clearFlag();
  endtask

  task automatic testZeroPeriod();
    cfgWrite(1'b1, 16'd0, 3'd2);
    repeat (4) @(negedge clk);
    pulseAccess();
    chk("R2", "csN low", csN, 1'b0);
    @(negedge clk); bufFull = 1'b1;
    edgeSample();
    chk("R4", "low at full edge", csN, 1'b0);
    edgeSample();
    chk("R4", "release next edge", csN, 1'b1);
    chk("R4", "flag", timeoutFlag, 1'b1);
    @(negedge clk); bufFull = 1'b0;
    clearFlag();
  endtask

  task automatic testMode();
    cfgWrite(1'b1, 16'd2, 3'd2);
    repeat (4) @(negedge clk);
    fnMode = 2'b10;
    pulseAccess();
    @(negedge clk); bufFull = 1'b1;
    repeat (20) edgeSample();
    chk("R6", "no release outside mapped mode", csN, 1'b0);
    chk("R6", "no flag outside mapped mode", timeoutFlag, 1'b0);
    @(negedge clk); fnMode = 2'b11;
    repeat (4) edgeSample();
    chk("R6", "release after mode back", csN, 1'b1);
    @(negedge clk); bufFull = 1'b0;
    clearFlag();
  endtask

  task automatic testDisabled();
    cfgWrite(1'b0, 16'd0, 3'd2);
    repeat (4) @(negedge clk);
    pulseAccess();
    @(negedge clk); bufFull = 1'b1;
    repeat (40) edgeSample();
    chk("R5", "held low when disabled", csN, 1'b0);
    chk("R5", "no flag when disabled", timeoutFlag, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTimeout();
    testMinHigh();
    testFlagIrq();
    testCancel();
    testZeroPeriod();
    testMode();
    testDisabled();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #50000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule